// File: doc/BRIEF.md
# Parallel Camera Pixel Capture Interface

This block takes a parallel image-sensor bus (pixel clock, line sync, frame sync and up to 14 data lines) and turns the pixel stream into 32-bit words. These words leave on a valid/ready output. The pixel clock is treated as a slow data input and is oversampled by the system clock `clk`. A capture event is the system-clock cycle in which the selected pixel-clock transition is seen. On that event the data lines and both syncs are taken together.

A sample is kept only when neither sync is active, meaning it falls inside the active part of a line. Narrow 8-bit samples are packed four to a word and wider samples two to a word, both lowest lane first. A word that is only partly filled when a sync becomes active is sent out with its empty lanes at zero. The block also marks frame boundaries with single-cycle pulses. If a completed word meets an output that is still stalled, the word is dropped and an overrun pulse is raised.

The configuration inputs are held steady by the surrounding logic while a frame is in progress.

Top module: `pixcap`

## Requirements
- R1: `cfg_width` selects the sample width: 0 = 8 bits, 1 = 10 bits, 2 = 12 bits, 3 = 14 bits. Data lines above the selected width have no effect on the output words.
- R2: With width code 0, four accepted samples make one word. The first sample goes in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R3: With width codes 1 to 3, two accepted samples make one word. The first goes in bits [15:0] and the second in bits [31:16], each zero-extended above the selected width.
- R4: With `cfg_pclk_rise` = 1, samples are taken on the 0-to-1 transition of `pclk`. With `cfg_pclk_rise` = 0 they are taken on the 1-to-0 transition. Data present only at the other transition is never captured, and output words change only right after a `pclk` transition.
- R5: A sync is active when its pin equals its polarity bit (`cfg_hs_high` for `hsync`, `cfg_vs_high` for `vsync`).
- R6: A sample taken while either sync is active is discarded.
- R7: When a sync becomes active while a word is partly filled, that word is emitted with its unfilled lanes at zero. The next accepted sample starts again at the lowest lane.
- R8: `frame_start` pulses for one cycle when a capture event sees the frame sync go inactive. `frame_end` pulses for one cycle when a capture event sees it go active. The two never pulse together. After reset the frame sync is taken as active.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. A word completed in that state is dropped and `overrun` pulses for one cycle.
- R10: Line sync and frame sync changing on the same pixel-clock transition are both decoded: a frame start and a line start on one transition, or a frame end and a line-end flush on one transition.
- R11: During and right after reset, `out_valid`, `frame_start`, `frame_end` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Sample width code |
| cfg_pclk_rise | input | 1 | 1: capture on rising pixel-clock edge, 0: falling |
| cfg_hs_high | input | 1 | Active level of the line sync |
| cfg_vs_high | input | 1 | Active level of the frame sync |
| pclk | input | 1 | Sensor pixel clock, oversampled |
| hsync | input | 1 | Line sync pin |
| vsync | input | 1 | Frame sync pin |
| pdata | input | 14 | Sensor data lines |
| out_ready | input | 1 | Downstream accepts a word |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Packed output word |
| frame_start | output | 1 | One-cycle frame-start pulse |
| frame_end | output | 1 | One-cycle frame-end pulse |
| overrun | output | 1 | One-cycle pulse when a word is dropped |

## Verification
The hardest case to reach is a second word completing while the first is still stalled. This needs the output held not-ready across at least eight pixel-clock transitions. The bench therefore drops `out_ready` for a whole line and releases it only after the line has ended. It then checks that the first word survived and that exactly one overrun was seen. Edge selection is proven by giving the data lines the inverted value at the non-capture transition, so a block that samples on the wrong edge produces the inverted words.

// File: rtl/pixcap.sv
module pixcap #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_pclk_rise,
  input  logic          cfg_hs_high,
  input  logic          cfg_vs_high,
  input  logic          pclk,
  input  logic          hsync,
  input  logic          vsync,
  input  logic [DW-1:0] pdata,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [31:0]   out_data,
  output logic          frame_start,
  output logic          frame_end,
  output logic          overrun
);
  localparam int WW = 32;

  logic          pclk_q, vs_q;
  logic [1:0]    lane;
  logic [WW-1:0] acc, acc_n;
  logic [DW-1:0] mask;

  wire ev     = cfg_pclk_rise ? (pclk & ~pclk_q) : (~pclk & pclk_q);
  wire hs_on  = (hsync == cfg_hs_high);
  wire vs_on  = (vsync == cfg_vs_high);
  wire narrow = (cfg_width == 2'd0);
  wire take   = ev & ~hs_on & ~vs_on;
  wire last   = narrow ? (lane == 2'd3) : lane[0];
  wire flush  = ev & (hs_on | vs_on) & (lane != 2'd0);
  wire emit   = (take & last) | flush;
  wire [WW-1:0] word = flush ? acc : acc_n;
  wire [DW-1:0] samp = pdata & mask;

  always_comb begin
    case (cfg_width)
      2'd0:    mask = DW'(14'h00FF);
      2'd1:    mask = DW'(14'h03FF);
      2'd2:    mask = DW'(14'h0FFF);
      default: mask = DW'(14'h3FFF);
    endcase
  end

  always_comb begin
    acc_n = acc;
    if (narrow) acc_n[{lane, 3'b000} +: 8] = samp[7:0];
    else        acc_n[{lane[0], 4'b0000} +: 16] = 16'(samp);
  end

  always_ff @(posedge clk) begin
    pclk_q <= pclk;
    if (!rst_n) begin
      vs_q        <= 1'b1;
      lane        <= '0;
      acc         <= '0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      frame_start <= ev & vs_q & ~vs_on;
      frame_end   <= ev & ~vs_q & vs_on;
      overrun     <= emit & out_valid & ~out_ready;
      if (ev) vs_q <= vs_on;

      if (take) begin
        if (last) begin
          lane <= '0;
          acc  <= '0;
        end else begin
          lane <= lane + 2'd1;
          acc  <= acc_n;
        end
      end else if (ev & (hs_on | vs_on)) begin
        lane <= '0;
        acc  <= '0;
      end

      if (emit & (~out_valid | out_ready)) begin
        out_valid <= 1'b1;
        out_data  <= word;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pixcap_chk.sv
module pixcap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pclk,
  input logic        out_ready,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        frame_start,
  input logic        frame_end,
  input logic        overrun
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(out_valid && !out_ready));

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && frame_end));

  p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  p_end_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  p_word_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(pclk, 1) != $past(pclk, 2));
endmodule

bind pixcap pixcap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pclk(pclk), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .frame_start(frame_start),
  .frame_end(frame_end), .overrun(overrun)
);

// File: tb/pixcap_test.sv
`timescale 1ns/1ps
module pixcap_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_width = 0;
  logic cfg_pclk_rise = 1, cfg_hs_high = 1, cfg_vs_high = 1;
  logic pclk = 0, hsync = 1, vsync = 1, out_ready = 1;
  logic [13:0] pdata = 0;
  logic out_valid, frame_start, frame_end, overrun;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  pixcap uut (.*);

  typedef struct packed {
    logic [1:0] m;
    logic [13:0] s0, s1, s2, s3;
    logic [31:0] e0, e1;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{2'd0, 14'h3A11, 14'h0022, 14'h1F33, 14'h2044, 32'h44332211, 32'h0},
    '{2'd0, 14'h00FF, 14'h0000, 14'h0080, 14'h0001, 32'h018000FF, 32'h0},
    '{2'd1, 14'h3FFF, 14'h0155, 14'h0200, 14'h03FF, 32'h015503FF, 32'h03FF0200},
    '{2'd2, 14'h3ABC, 14'h0123, 14'h0FFF, 14'h3000, 32'h01230ABC, 32'h00000FFF},
    '{2'd3, 14'h3FFF, 14'h1234, 14'h2AAA, 14'h1555, 32'h12343FFF, 32'h15552AAA}
  };

  int checks = 0, errors = 0;
  int rx_n = 0, fs_n = 0, fe_n = 0, ov_n = 0;
  logic [31:0] rx [64];
  logic hs_act = 1, vs_act = 1;

  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready && rx_n < 64) begin rx[rx_n] = out_data; rx_n++; end
    if (frame_start) fs_n++;
    if (frame_end) fe_n++;
    if (overrun) ov_n++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pix(input logic [13:0] d, input logic hs, input logic vs);
    @(posedge clk); #1;
    pdata = ~d; pclk = ~cfg_pclk_rise;
    repeat (2) @(posedge clk); #1;
    pdata = d;
    hsync = hs ? cfg_hs_high : ~cfg_hs_high;
    vsync = vs ? cfg_vs_high : ~cfg_vs_high;
    repeat (2) @(posedge clk); #1;
    pclk = cfg_pclk_rise;
    repeat (3) @(posedge clk);
  endtask

  task automatic run_line(input logic [13:0] a, b, c, d, input int n);
    pix(14'h00EE, 1, 0);
    if (n > 0) pix(a, 0, 0);
    if (n > 1) pix(b, 0, 0);
    if (n > 2) pix(c, 0, 0);
    if (n > 3) pix(d, 0, 0);
    pix(14'h0000, 1, 0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, fs0, fe0;
    repeat (3) @(negedge clk);
    chk("R11 reset out_valid", out_valid, 0);
    chk("R11 reset pulses", {frame_start, frame_end, overrun}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R11 after reset out_valid", out_valid, 0);

    pix(0, 1, 1);
    pix(0, 1, 1);
    chk("R8 no pulse while frame sync stays active", fs_n + fe_n, 0);
    pix(0, 1, 0);
    chk("R8 frame_start count", fs_n, 1);

    for (int i = 0; i < 5; i++) begin
      cfg_width = TBL[i].m;
      base = rx_n;
      run_line(TBL[i].s0, TBL[i].s1, TBL[i].s2, TBL[i].s3, 4);
      if (TBL[i].m == 0) begin
        chk("R1 R2 R6 word count narrow", rx_n - base, 1);
        chk("R1 R2 narrow word", rx[base], TBL[i].e0);
      end else begin
        chk("R3 R6 word count wide", rx_n - base, 2);
        chk("R1 R3 wide word 0", rx[base], TBL[i].e0);
        chk("R1 R3 wide word 1", rx[base+1], TBL[i].e1);
      end
    end

    cfg_width = 0;
    base = rx_n;
    run_line(14'h01, 14'h02, 14'h03, 0, 3);
    run_line(14'h10, 14'h11, 14'h12, 14'h13, 4);
    chk("R7 partial count", rx_n - base, 2);
    chk("R7 partial narrow word", rx[base], 32'h00030201);
    chk("R7 lane restart", rx[base+1], 32'h13121110);

    cfg_width = 1;
    base = rx_n;
    run_line(14'h3D55, 0, 0, 0, 1);
    chk("R7 partial wide word", rx[base], 32'h00000155);

    cfg_width = 0; cfg_pclk_rise = 0;
    pclk = 1;
    repeat (3) @(posedge clk);
    base = rx_n;
    run_line(14'h5A, 14'h6B, 14'h7C, 14'h8D, 4);
    chk("R4 falling edge word", rx[base], 32'h8D7C6B5A);
    cfg_pclk_rise = 1;
    pclk = 0;
    repeat (3) @(posedge clk);

    cfg_hs_high = 0; cfg_vs_high = 0;
    pix(0, 1, 0);
    base = rx_n;
    run_line(14'h21, 14'h43, 14'h65, 14'h87, 4);
    chk("R5 active-low sync count", rx_n - base, 1);
    chk("R5 active-low sync word", rx[base], 32'h87654321);
    chk("R5 no frame pulse from polarity change", fe_n, 0);
    cfg_hs_high = 1; cfg_vs_high = 1;
    pix(0, 1, 0);

    fs0 = fs_n; fe0 = fe_n; base = rx_n;
    pix(0, 1, 1);
    chk("R8 frame_end count", fe_n - fe0, 1);
    pix(14'hA1, 0, 0);
    chk("R10 frame start with line start", fs_n - fs0, 1);
    pix(14'hB2, 0, 0);
    pix(14'hC3, 0, 0);
    pix(14'hD4, 0, 0);
    pix(14'hE5, 0, 0);
    pix(0, 1, 1);
    repeat (3) @(posedge clk);
    chk("R10 words on combined edges", rx_n - base, 2);
    chk("R10 first word", rx[base], 32'hD4C3B2A1);
    chk("R10 flush on combined end", rx[base+1], 32'h000000E5);
    chk("R10 frame end with line end", fe_n - fe0, 2);
    pix(0, 1, 0);

    @(posedge clk); #1 out_ready = 0;
    base = rx_n; fs0 = ov_n;
    pix(14'hEE, 1, 0);
    for (int k = 1; k <= 8; k++) pix(14'(k), 0, 0);
    pix(0, 1, 0);
    @(negedge clk);
    chk("R9 held valid", out_valid, 1);
    chk("R9 held data", out_data, 32'h04030201);
    chk("R9 overrun count", ov_n - fs0, 1);
    @(posedge clk); #1 out_ready = 1;
    repeat (3) @(posedge clk);
    chk("R9 released count", rx_n - base, 1);
    chk("R9 released word", rx[base], 32'h04030201);
    @(negedge clk);
    chk("R9 valid drops", out_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule